// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache Controller

This block sits between a processor's load/store port and a block-oriented memory. It holds 128 sets of two ways, each way a four-word line with a tag, a valid flag and a modified flag, plus one recency bit per set. Loads and stores that hit finish in the cycle they are presented. Stores only modify the cached line, and main memory sees new data only when a modified line is pushed out to make room.

A miss stalls the processor while the controller fetches the missing block. Before the fetch it writes the chosen victim line back, but only if that line is valid and modified. The original access then completes against the freshly installed line. A store miss fetches the block first and merges the store word afterwards. An access therefore costs zero, one or two memory transactions. The processor must hold its request fields stable while the stall output is high.

Top module: `wbwa_cache`

## Requirements
- R1: A load whose tag matches a valid way of its set completes in its first cycle: cpu_stall stays low, cpu_rdata carries the addressed word, and no memory request is raised.
- R2: A store hit writes only the cached word and raises no memory transaction. The memory copy of that word stays unchanged until the line is evicted.
- R3: A store miss fetches the whole block, then merges the store word into the installed line and marks it modified. A later load of that word returns the stored value.
- R4: A miss whose victim is invalid or unmodified costs exactly one block read. cpu_stall is high from the first cycle of the access until the access completes.
- R5: A miss whose victim is valid and modified issues one block write first, carrying the victim's tag and index in the address and the line's latest contents as data. It then issues one block read, and a write acknowledge is always followed directly by the read request.
- R6: A line installed by a load miss is unmodified, so evicting it later causes no writeback.
- R7: Each set keeps a recency bit. The way referenced by a completed access becomes most recent, and when both ways are valid a miss replaces the other way.
- R8: A miss into a set that still has an invalid way fills that way and never writes back.
- R9: The memory request keeps its address and direction stable until mem_ack is high. The block address has bits [3:0] at zero, and read data is taken in the acknowledge cycle.
- R10: Address fields are tag [31:11], set index [10:4] and word [3:2]; bits [1:0] are ignored. At most one way matches a lookup. Word k of a block occupies bits [32k+31:32k] of mem_wdata and mem_rdata.
- R11: After reset every line is invalid. With no request pending, cpu_stall and mem_req are low, and the first access to any address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Processor access request, held until not stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the word accessed |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when cpu_req is high and cpu_stall is low |
| cpu_stall | output | 1 | High while the presented access has not completed |
| mem_req | output | 1 | Block transaction request |
| mem_we | output | 1 | 1 = block writeback, 0 = block read |
| mem_addr | output | 32 | Block-aligned memory address |
| mem_wdata | output | 128 | Writeback block data |
| mem_rdata | input | 128 | Refill block data, taken when mem_ack is high |
| mem_ack | input | 1 | Memory completes the current transaction |

## Verification
On the cycle that follows a refill acknowledge, the lookup that completes the access also merges a store word, sets the modified flag and moves the recency bit. All three updates land in one cycle. A directed sequence, then a pseudo-random sweep over three tags, two sets and four words, provokes this with store misses into full sets whose recency victim is already modified. A reference model of flat memory, line state and recency, computed from the requirements, predicts every load value, the number of writebacks and refills per access, the writeback address and the written-back data, so a merge lost or misplaced in that shared cycle surfaces in a later eviction or load.

// File: rtl/wbc_pkg.sv
// Shared constants and controller state encoding for the write-back cache.
// Assumes two ways; the single recency bit per set depends on that.
package wbc_pkg;
    localparam int NUM_WAYS = 2;

    typedef enum logic [1:0] {
        ST_LOOK  = 2'd0,
        ST_WB    = 2'd1,
        ST_FILL  = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/wbc_meta.sv
// Line state store: valid, modified and tag per way and set, plus one
// recency bit per set. It compares tags in every way at once, picks a victim
// (invalid way first, then least recent) and serves the tag of any way for
// writeback addressing. Assumes one index is in use per cycle.
module wbc_meta
    import wbc_pkg::*;
#(
    parameter int NUM_SETS = 128,
    parameter int TAG_W    = 21
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(NUM_SETS)-1:0] idx,
    input  logic [TAG_W-1:0]           lk_tag,
    output logic [NUM_WAYS-1:0]        hit_vec,
    output logic                       vict_way,
    output logic                       vict_dirty,
    input  logic                       peek_way,
    output logic [TAG_W-1:0]           peek_tag,
    input  logic                       fill_en,
    input  logic                       fill_way,
    input  logic [TAG_W-1:0]           fill_tag,
    input  logic                       mark_en,
    input  logic                       mark_way,
    input  logic                       touch_en,
    input  logic                       touch_way
);
    logic [NUM_SETS-1:0] vld_q [NUM_WAYS];
    logic [NUM_SETS-1:0] dty_q [NUM_WAYS];
    logic [TAG_W-1:0]    tag_q [NUM_WAYS][NUM_SETS];
    logic [NUM_SETS-1:0] mru_q;

    // One tag comparator per way.
    for (genvar gw = 0; gw < NUM_WAYS; gw++) begin : g_cmp
        assign hit_vec[gw] = vld_q[gw][idx] && (tag_q[gw][idx] == lk_tag);
    end

    // Victim choice: an empty way wins, otherwise the way not used last.
    always_comb begin
        if (!vld_q[0][idx])      vict_way = 1'b0;
        else if (!vld_q[1][idx]) vict_way = 1'b1;
        else                     vict_way = ~mru_q[idx];
    end

    assign vict_dirty = vld_q[vict_way][idx] && dty_q[vict_way][idx];
    assign peek_tag   = tag_q[peek_way][idx];

    // Valid, modified and recency flags, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                vld_q[w] <= '0;
                dty_q[w] <= '0;
            end
            mru_q <= '0;
        end else begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                if (fill_en && fill_way == 1'(w)) begin
                    vld_q[w][idx] <= 1'b1;
                    dty_q[w][idx] <= 1'b0;
                end else if (mark_en && mark_way == 1'(w)) begin
                    dty_q[w][idx] <= 1'b1;
                end
            end
            if (touch_en) mru_q[idx] <= touch_way;
        end
    end

    // Tag storage, written only when a block is installed.
    always_ff @(posedge clk) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (fill_en && fill_way == 1'(w)) tag_q[w][idx] <= fill_tag;
        end
    end
endmodule

// File: rtl/wbc_data.sv
// Line data store: whole-block install from memory, single-word store merge,
// word read through a way mux and whole-block read for writeback.
// Assumes install and merge never target the same cycle (the controller
// guarantees it). Contents are not reset.
module wbc_data
    import wbc_pkg::*;
#(
    parameter int NUM_SETS  = 128,
    parameter int BLK_WORDS = 4,
    parameter int WORD_W    = 32
) (
    input  logic                          clk,
    input  logic [$clog2(NUM_SETS)-1:0]   idx,
    input  logic [$clog2(BLK_WORDS)-1:0]  wsel,
    input  logic                          rd_way,
    output logic [WORD_W-1:0]             rd_word,
    input  logic                          blk_way,
    output logic [BLK_WORDS*WORD_W-1:0]   blk_out,
    input  logic                          fill_en,
    input  logic                          fill_way,
    input  logic [BLK_WORDS*WORD_W-1:0]   fill_blk,
    input  logic                          wr_en,
    input  logic                          wr_way,
    input  logic [WORD_W-1:0]             wr_data
);
    logic [WORD_W-1:0] arr_q [NUM_WAYS][NUM_SETS][BLK_WORDS];

    // Block install or word merge into the selected way.
    always_ff @(posedge clk) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (fill_en && fill_way == 1'(w)) begin
                for (int k = 0; k < BLK_WORDS; k++)
                    arr_q[w][idx][k] <= fill_blk[k*WORD_W +: WORD_W];
            end else if (wr_en && wr_way == 1'(w)) begin
                arr_q[w][idx][wsel] <= wr_data;
            end
        end
    end

    assign rd_word = arr_q[rd_way][idx][wsel];

    // Victim block assembled word by word for writeback.
    for (genvar gk = 0; gk < BLK_WORDS; gk++) begin : g_blk
        assign blk_out[gk*WORD_W +: WORD_W] = arr_q[blk_way][idx][gk];
    end
endmodule

// File: rtl/wbc_ctl.sv
// Miss sequencer: lookup, optional writeback of a modified victim, refill,
// then back to lookup where the original access completes as a hit.
// Assumes the processor holds its request while stalled and memory answers
// each request with a single-cycle acknowledge.
module wbc_ctl
    import wbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_req,
    input  logic       hit,
    input  logic       vict_way_in,
    input  logic       vict_dirty,
    input  logic       mem_ack,
    output ctl_state_t state,
    output logic       vict_q,
    output logic       acc_done,
    output logic       fill_en,
    output logic       mem_req,
    output logic       mem_we
);
    // State and latched victim way.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_LOOK;
            vict_q <= 1'b0;
        end else begin
            unique case (state)
                ST_LOOK: begin
                    if (cpu_req && !hit) begin
                        vict_q <= vict_way_in;
                        state  <= vict_dirty ? ST_WB : ST_FILL;
                    end
                end
                ST_WB:   if (mem_ack) state <= ST_FILL;
                ST_FILL: if (mem_ack) state <= ST_LOOK;
                default: state <= ST_LOOK;
            endcase
        end
    end

    // Handshake and update strobes decoded from state.
    always_comb begin
        mem_req  = (state == ST_WB) || (state == ST_FILL);
        mem_we   = (state == ST_WB);
        fill_en  = (state == ST_FILL) && mem_ack;
        acc_done = (state == ST_LOOK) && cpu_req && hit;
    end
endmodule

// File: rtl/wbwa_cache.sv
// Two-way set-associative write-back, write-allocate data cache controller.
// Splits the processor address, wires the line state store, data store and
// miss sequencer together and forms the memory-side block address.
// Assumes cpu_* fields are held while cpu_stall is high.
module wbwa_cache
    import wbc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 4,
    parameter int NUM_SETS  = 128
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cpu_req,
    input  logic                        cpu_we,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic [WORD_W-1:0]           cpu_wdata,
    output logic [WORD_W-1:0]           cpu_rdata,
    output logic                        cpu_stall,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [BLK_WORDS*WORD_W-1:0] mem_wdata,
    input  logic [BLK_WORDS*WORD_W-1:0] mem_rdata,
    input  logic                        mem_ack
);
    localparam int BOFF_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = $clog2(BLK_WORDS);
    localparam int OFF_W  = BOFF_W + WSEL_W;
    localparam int IDX_W  = $clog2(NUM_SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

    logic [IDX_W-1:0]    idx;
    logic [TAG_W-1:0]    ctag;
    logic [WSEL_W-1:0]   wsel;
    logic [NUM_WAYS-1:0] hit_vec;
    logic                hit, hit_way;
    logic                vict_comb, vict_dirty, vict_q, sel_way;
    logic [TAG_W-1:0]    peek_tag;
    logic                acc_done, fill_en, store_done;
    ctl_state_t          state;
    logic                unused_byte_bits;

    // Address field split.
    assign idx  = cpu_addr[OFF_W +: IDX_W];
    assign ctag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign wsel = cpu_addr[BOFF_W +: WSEL_W];
    assign unused_byte_bits = ^cpu_addr[BOFF_W-1:0];

    assign hit        = |hit_vec;
    assign hit_way    = hit_vec[1];
    assign sel_way    = (state == ST_LOOK) ? vict_comb : vict_q;
    assign store_done = acc_done && cpu_we;

    wbc_meta #(.NUM_SETS(NUM_SETS), .TAG_W(TAG_W)) u_meta (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (idx),
        .lk_tag     (ctag),
        .hit_vec    (hit_vec),
        .vict_way   (vict_comb),
        .vict_dirty (vict_dirty),
        .peek_way   (sel_way),
        .peek_tag   (peek_tag),
        .fill_en    (fill_en),
        .fill_way   (vict_q),
        .fill_tag   (ctag),
        .mark_en    (store_done),
        .mark_way   (hit_way),
        .touch_en   (acc_done),
        .touch_way  (hit_way)
    );

    wbc_data #(.NUM_SETS(NUM_SETS), .BLK_WORDS(BLK_WORDS), .WORD_W(WORD_W)) u_data (
        .clk      (clk),
        .idx      (idx),
        .wsel     (wsel),
        .rd_way   (hit_way),
        .rd_word  (cpu_rdata),
        .blk_way  (sel_way),
        .blk_out  (mem_wdata),
        .fill_en  (fill_en),
        .fill_way (vict_q),
        .fill_blk (mem_rdata),
        .wr_en    (store_done),
        .wr_way   (hit_way),
        .wr_data  (cpu_wdata)
    );

    wbc_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req     (cpu_req),
        .hit         (hit),
        .vict_way_in (vict_comb),
        .vict_dirty  (vict_dirty),
        .mem_ack     (mem_ack),
        .state       (state),
        .vict_q      (vict_q),
        .acc_done    (acc_done),
        .fill_en     (fill_en),
        .mem_req     (mem_req),
        .mem_we      (mem_we)
    );

    // Block address: victim tag on writeback, requested tag on refill.
    assign mem_addr  = {(mem_we ? peek_tag : ctag), idx, {OFF_W{1'b0}}};
    assign cpu_stall = cpu_req && !acc_done;
endmodule

// File: rtl/wbwa_cache_chk.sv
// Protocol and ordering checks for the cache controller, bound to the top.
// Assumes the processor holds its request while stalled.
module wbwa_cache_chk #(
    parameter int ADDR_W   = 32,
    parameter int OFF_W    = 4,
    parameter int NUM_WAYS = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cpu_req,
    input logic                cpu_we,
    input logic [ADDR_W-1:0]   cpu_addr,
    input logic                cpu_stall,
    input logic                mem_req,
    input logic                mem_we,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic                mem_ack,
    input logic [NUM_WAYS-1:0] hit_vec
);
    // R9: request fields hold until acknowledged
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R9: block addresses are aligned
    a_r9_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[OFF_W-1:0] == '0);

    // R5: a finished writeback is followed directly by a refill request
    a_r5_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack |=> mem_req && !mem_we);

    // R3: the refill reads the block the processor asked for
    a_r3_fill_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |-> mem_addr[ADDR_W-1:OFF_W] == cpu_addr[ADDR_W-1:OFF_W]);

    // R4: the access completes in the cycle after the refill acknowledge
    a_r4_fill_completes: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ack |=> !mem_req && !cpu_stall);

    // R10: never more than one matching way
    a_r10_one_way: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R1: a lookup hit completes without stalling
    a_r1_hit_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && !mem_req && (|hit_vec) |-> !cpu_stall);

    // R2: a completing store raises no memory request
    a_r2_store_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_we && !cpu_stall |-> !mem_req);

    // R11: the processor is stalled whenever memory is busy
    a_r11_busy_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cpu_stall);
endmodule

bind wbwa_cache wbwa_cache_chk #(
    .ADDR_W   (ADDR_W),
    .OFF_W    (OFF_W),
    .NUM_WAYS (wbc_pkg::NUM_WAYS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_stall (cpu_stall),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .hit_vec   (hit_vec)
);

// File: tb/wbwa_cache_tb.sv
`timescale 1ns/100ps
module wbwa_cache_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
    logic [31:0]  cpu_rdata;
    logic         cpu_stall;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [127:0] mem_rdata = '0;
    logic         mem_ack = 1'b0;

    int n_run = 0, n_fail = 0;
    int wb_cnt = 0, fill_cnt = 0, lat = 0;
    logic [31:0] last_wb = '0;

    logic [31:0] mem_words [logic [29:0]];
    logic [31:0] ref_w     [logic [29:0]];
    bit          rv  [2][128];
    bit          rdy [2][128];
    logic [20:0] rt  [2][128];
    bit          rm  [128];

    always #2 clk = ~clk;

    wbwa_cache u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    function automatic logic [31:0] pat(input logic [29:0] wa);
        return {wa, 2'b00} ^ 32'hC3A5_1E0F;
    endfunction
    function automatic logic [31:0] rd_mem(input logic [29:0] wa);
        return mem_words.exists(wa) ? mem_words[wa] : pat(wa);
    endfunction
    function automatic logic [31:0] rd_ref(input logic [29:0] wa);
        return ref_w.exists(wa) ? ref_w[wa] : pat(wa);
    endfunction
    function automatic logic [31:0] mk(input logic [20:0] t, input logic [6:0] s, input logic [1:0] w);
        return {t, s, w, 2'b00};
    endfunction

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    // Memory model: answers each request two cycles later with a one-cycle ack.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            lat = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (lat == 2) begin
                lat = 0;
                mem_ack = 1'b1;
                chk(mem_addr[3:0] == 4'h0, "R9 block alignment", {28'h0, mem_addr[3:0]}, 32'h0);
                if (mem_we) begin
                    wb_cnt++;
                    last_wb = mem_addr;
                    for (int k = 0; k < 4; k++) begin
                        chk(mem_wdata[k*32 +: 32] == rd_ref(mem_addr[31:2] + 30'(k)),
                            "R5 writeback data", mem_wdata[k*32 +: 32], rd_ref(mem_addr[31:2] + 30'(k)));
                        mem_words[mem_addr[31:2] + 30'(k)] = mem_wdata[k*32 +: 32];
                    end
                end else begin
                    fill_cnt++;
                    for (int k = 0; k < 4; k++)
                        mem_rdata[k*32 +: 32] = rd_mem(mem_addr[31:2] + 30'(k));
                end
            end else begin
                lat++;
            end
        end
    end

    // One processor access, judged against the reference model. Starts at a negedge.
    task automatic acc(input bit we, input logic [31:0] a, input logic [31:0] d, input string r);
        int wb0, f0, hw, way, ew, guard, s;
        logic [20:0] t;
        logic [31:0] ewa, got, expd;
        bit first_stall;
        wb0 = wb_cnt; f0 = fill_cnt;
        s = int'(a[10:4]); t = a[31:11];
        hw = -1; ew = 0; ewa = '0; way = 0;
        if (rv[0][s] && rt[0][s] == t) hw = 0;
        else if (rv[1][s] && rt[1][s] == t) hw = 1;
        if (hw < 0) begin
            if (!rv[0][s]) way = 0;
            else if (!rv[1][s]) way = 1;
            else way = rm[s] ? 0 : 1;
            if (rv[way][s] && rdy[way][s]) begin
                ew = 1;
                ewa = {rt[way][s], a[10:4], 4'h0};
            end
        end else begin
            way = hw;
        end
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        #0.5;
        first_stall = cpu_stall;
        guard = 0;
        while (cpu_stall && guard < 100) begin
            @(negedge clk); #0.5;
            guard++;
        end
        got = cpu_rdata;
        expd = rd_ref(a[31:2]);
        chk(first_stall == (hw < 0), {r, " stall in first cycle"}, 32'(first_stall), 32'(hw < 0));
        chk(!cpu_stall, {r, " access completes"}, 32'(cpu_stall), 32'h0);
        if (!we) chk(got == expd, {r, " load data"}, got, expd);
        chk(wb_cnt - wb0 == ew, {r, " writeback count"}, 32'(wb_cnt - wb0), 32'(ew));
        chk(fill_cnt - f0 == int'(hw < 0), {r, " refill count"}, 32'(fill_cnt - f0), 32'(hw < 0));
        if (ew != 0) chk(last_wb == ewa, {r, " writeback address"}, last_wb, ewa);
        @(posedge clk);
        if (hw < 0) begin
            rv[way][s] = 1'b1; rt[way][s] = t; rdy[way][s] = 1'b0;
        end
        if (we) begin
            rdy[way][s] = 1'b1;
            ref_w[a[31:2]] = d;
        end
        rm[s] = way[0];
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL R9 watchdog expired: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [20:0] ta, tb_, tc;
        logic [20:0] tg [3];
        logic [31:0] x;
        ta = 21'h000A1; tb_ = 21'h0B002; tc = 21'h001C3;
        tg[0] = 21'h0; tg[1] = 21'h1; tg[2] = 21'h15A3C;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #0.5;
        // R11: idle after reset
        chk(!cpu_stall, "R11 idle stall low", 32'(cpu_stall), 32'h0);
        chk(!mem_req, "R11 idle no memory request", 32'(mem_req), 32'h0);
        @(negedge clk);
        acc(1'b0, mk(ta, 7'd5, 2'd0), '0, "R11 R4 first load misses clean");
        acc(1'b0, mk(ta, 7'd5, 2'd0), '0, "R1 load hit");
        acc(1'b1, mk(ta, 7'd5, 2'd1), 32'h1111_2222, "R2 store hit");
        chk(rd_mem(mk(ta, 7'd5, 2'd1) >> 2) == pat(mk(ta, 7'd5, 2'd1) >> 2), "R2 memory untouched",
            rd_mem(mk(ta, 7'd5, 2'd1) >> 2), pat(mk(ta, 7'd5, 2'd1) >> 2));
        acc(1'b0, mk(ta, 7'd5, 2'd1), '0, "R2 read back store hit");
        acc(1'b1, mk(tb_, 7'd5, 2'd2), 32'h3333_4444, "R8 R3 store miss into invalid way");
        acc(1'b0, mk(tb_, 7'd5, 2'd2), '0, "R3 merged word visible");
        acc(1'b0, mk(ta, 7'd5, 2'd0), '0, "R7 touch first line");
        acc(1'b0, mk(tc, 7'd5, 2'd3), '0, "R5 R7 dirty recency victim");
        acc(1'b0, mk(ta, 7'd5, 2'd0), '0, "R7 recent line kept");
        acc(1'b0, mk(tb_, 7'd5, 2'd2), '0, "R6 clean victim no writeback");
        acc(1'b1, mk(tc, 7'd5, 2'd0), 32'h5555_6666, "R5 R3 store miss over dirty line");
        acc(1'b0, mk(tc, 7'd5, 2'd0), '0, "R3 merge after refill");
        acc(1'b1, mk(ta, 7'd9, 2'd3) | 32'h3, 32'h7777_8888, "R10 byte bits ignored");
        acc(1'b0, mk(ta, 7'd9, 2'd3), '0, "R10 word field");
        // R10 R7 R5: sweep over three tags, two sets, four words
        x = 32'h1234_5678;
        for (int i = 0; i < 400; i++) begin
            x = x * 32'd1103515245 + 32'd12345;
            acc(x[25], mk(tg[x[17:16] % 2'd3], x[20] ? 7'd5 : 7'd127, x[23:22]),
                x ^ 32'hDEAD_0000, "R10 sweep");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule